// File: doc/BRIEF.md
# DRAM Power-Up and Self-Refresh Sequencer

This block drives the row strobe, the two byte-lane column strobes and the write-enable strobe of an EDO-style DRAM with a 16-bit data path. It handles two jobs. The first is bring-up after power is applied: a long quiet pause, then a fixed number of column-before-row refresh cycles. The second is moving the memory into self-refresh and back out of it. Normal reads, writes, page bursts, address muxing and the data bus belong to other logic. That logic waits for `ready` before it takes the strobes over.

Every minimum delay is a time in nanoseconds. It is turned into a clock-cycle count by ceiling division by the clock-period parameter, and no count is allowed below one cycle.

Self-refresh entry follows the column-before-row order: the column strobes fall first and the row strobe falls later. The row strobe is then held low for the minimum dwell time. An exit request that arrives during the dwell is stored until the dwell has elapsed. On exit, the column strobes may be released one cycle ahead of the row strobe. After that the row strobe stays high for a precharge time chosen by the speed-grade input.

Top module: `dram_selfrefresh_seq`

## Requirements
- R1: While `rst_n` is low, `ras_n`, `ucas_n`, `lcas_n` and `we_n` are all high, `ready` is low and `busy` is high. After `rst_n` rises, all four strobes stay high for at least ceil(200 us / period) clock cycles (25000 at 8 ns) before any strobe falls.
- R2: After the pause the block issues exactly 8 refresh cycles. In each one the column strobes are already low in the cycle before the row strobe falls. `ready` rises only after the last of them.
- R3: In self-refresh, `ras_n` stays low for at least ceil(100 us / period) cycles (12500 at 8 ns). An exit request that arrives earlier is held and acted on once that minimum has elapsed. An exit request that arrives after the minimum makes `ras_n` rise within 2 cycles.
- R4: After `ras_n` rises on self-refresh exit, `ready` stays low and `busy` stays high for at least the precharge time selected by `speed_grade`: 0 gives 90 ns, 1 gives 110 ns, and 2 or 3 give 130 ns. At 8 ns these are 12, 14 and 17 cycles.
- R5: On self-refresh exit the column strobes rise exactly one cycle before `ras_n` when early release is enabled and the period is at most 50 ns. Otherwise they rise on the same edge as `ras_n`. They never rise earlier than that.
- R6: `ucas_n` and `lcas_n` carry the same value in every cycle.
- R7: On self-refresh entry the column strobes fall while `ras_n` is high, and `ras_n` falls at least one cycle later. `we_n` is high at all times.
- R8: `ready` is high only while the block is idle with all strobes high. It falls on the edge that accepts an enter request. `busy` is the complement of `ready`.
- R9: `sr_enter_req` is ignored unless `ready` is high. `sr_exit_req` is ignored unless the block is in self-refresh. An ignored request changes no strobe and no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_enter_req | input | 1 | Request to enter self-refresh, sampled while ready |
| sr_exit_req | input | 1 | Request to leave self-refresh |
| speed_grade | input | 2 | Precharge grade: 0 = 90 ns, 1 = 110 ns, 2 or 3 = 130 ns |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| ready | output | 1 | Idle, and the memory may be handed to other logic |
| busy | output | 1 | A sequence is in progress |

## Verification
Every output is a flop loaded from the next-state decode. A request seen at a rising edge therefore shows on the strobes at that same edge: the column strobes fall at once on an accepted entry, and a late exit raises the column strobes at once and `ras_n` one edge later. The bench drives inputs and samples outputs only on falling edges, so every result is read half a cycle after the edge that made it. Intervals are measured by counting falling-edge samples in which a strobe or flag holds a level. These counts are compared with cycle counts that the bench computes from the nanosecond figures with its own ceiling arithmetic. The precharge count may run one sample longer than the minimum, and a late exit must show `ras_n` high within three samples of the request.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [3:0] {
    ST_PAUSE,
    ST_INIT_CAS,
    ST_INIT_RAS,
    ST_INIT_PRE,
    ST_READY,
    ST_SR_CAS,
    ST_SR_HOLD,
    ST_SR_CASREL,
    ST_SR_PRE
  } seq_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } strobe_t;

  // Time in ns to whole clock cycles: ceiling, never below one.
  function automatic int ns_to_cycles(input int delay_ns, input int period_ps);
    int q;
    q = (delay_ns * 1000 + period_ps - 1) / period_ps;
    if (q < 1) q = 1;
    return q;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Post-exit row precharge per speed grade, in ns.
  function automatic int rp_self_ns(input logic [1:0] grade);
    case (grade)
      2'd0:    return 90;
      2'd1:    return 110;
      default: return 130;
    endcase
  endfunction

  function automatic strobe_t strobes_for(input seq_state_e s);
    strobe_t v;
    v = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    case (s)
      ST_INIT_CAS, ST_SR_CAS:  v.cas_n = 1'b0;
      ST_INIT_RAS, ST_SR_HOLD: begin v.cas_n = 1'b0; v.ras_n = 1'b0; end
      ST_SR_CASREL:            v.ras_n = 1'b0;
      default:                 ;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int             W       = 16,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= RST_VAL;
    else if (load)         cnt <= len - W'(1);
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign done = (cnt == '0);

  // R3: an expired interval stays expired until reloaded (dwell never restarts)
  a_r3_timer_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && done) |=> done);

endmodule

// File: rtl/init_counter.sv
module init_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clr)   count <= '0;
    else if (inc)   count <= count + W'(1);
  end

  // R2: the warm-up refresh count never wraps
  a_r2_count_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (count != '0));

endmodule

// File: rtl/dram_selfrefresh_seq.sv
module dram_selfrefresh_seq
  import dram_seq_pkg::*;
#(
  parameter int CLK_PERIOD_PS     = 8000,
  parameter int POWERUP_NS        = 200000,
  parameter int SR_DWELL_NS       = 100000,
  parameter int INIT_REFRESHES    = 8,
  parameter int CAS_LEAD_NS       = 10,
  parameter int INIT_RAS_NS       = 80,
  parameter int INIT_PRE_NS       = 100,
  parameter int CAS_HOLD_LIMIT_NS = 50,
  parameter bit EARLY_CAS_RELEASE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sr_enter_req,
  input  logic       sr_exit_req,
  input  logic [1:0] speed_grade,
  output logic       ras_n,
  output logic       ucas_n,
  output logic       lcas_n,
  output logic       we_n,
  output logic       ready,
  output logic       busy
);
  localparam int PAUSE_CYC    = ns_to_cycles(POWERUP_NS, CLK_PERIOD_PS);
  localparam int DWELL_CYC    = ns_to_cycles(SR_DWELL_NS, CLK_PERIOD_PS);
  localparam int LEAD_CYC     = ns_to_cycles(CAS_LEAD_NS, CLK_PERIOD_PS);
  localparam int INIT_RAS_CYC = ns_to_cycles(INIT_RAS_NS, CLK_PERIOD_PS);
  localparam int INIT_PRE_CYC = ns_to_cycles(INIT_PRE_NS, CLK_PERIOD_PS);
  localparam int RP0_CYC      = ns_to_cycles(rp_self_ns(2'd0), CLK_PERIOD_PS);
  localparam int RP1_CYC      = ns_to_cycles(rp_self_ns(2'd1), CLK_PERIOD_PS);
  localparam int RP2_CYC      = ns_to_cycles(rp_self_ns(2'd2), CLK_PERIOD_PS);
  localparam int MAX_CYC      = max_int(max_int(PAUSE_CYC, DWELL_CYC),
                                max_int(max_int(LEAD_CYC, INIT_RAS_CYC),
                                        max_int(INIT_PRE_CYC, RP2_CYC)));
  localparam int TW           = $clog2(MAX_CYC + 1);
  localparam int CW           = $clog2(INIT_REFRESHES + 1);
  localparam bit EARLY_OK     = EARLY_CAS_RELEASE &&
                                (CLK_PERIOD_PS <= CAS_HOLD_LIMIT_NS * 1000);
  localparam logic [7:0] INIT_N8 = 8'(INIT_REFRESHES);

  seq_state_e     state_q, state_d, exit_next;
  strobe_t        next_strobes, strobe_q;
  logic           t_load, t_done;
  logic [TW-1:0]  t_len, rp_len;
  logic [CW-1:0]  init_cnt;
  logic           exit_pend_q;

  // Named internal events
  wire in_sr        = (state_q == ST_SR_CAS) || (state_q == ST_SR_HOLD);
  wire init_step    = (state_q == ST_INIT_PRE) && t_done;
  wire init_last    = (init_cnt == CW'(INIT_REFRESHES - 1));
  wire enter_accept = (state_q == ST_READY) && sr_enter_req;
  wire exit_seen    = sr_exit_req || exit_pend_q;
  wire sr_exit_fire = (state_q == ST_SR_HOLD) && t_done && exit_seen;

  // Variant: release CAS one cycle ahead of RAS only if that lead stays within the hold limit
  if (EARLY_OK) begin : g_early_rel
    assign exit_next = ST_SR_CASREL;
  end else begin : g_joint_rel
    assign exit_next = ST_SR_PRE;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PAUSE:     if (t_done) state_d = ST_INIT_CAS;
      ST_INIT_CAS:  if (t_done) state_d = ST_INIT_RAS;
      ST_INIT_RAS:  if (t_done) state_d = ST_INIT_PRE;
      ST_INIT_PRE:  if (t_done) state_d = init_last ? ST_READY : ST_INIT_CAS;
      ST_READY:     if (enter_accept) state_d = ST_SR_CAS;
      ST_SR_CAS:    if (t_done) state_d = ST_SR_HOLD;
      ST_SR_HOLD:   if (sr_exit_fire) state_d = exit_next;
      ST_SR_CASREL: state_d = ST_SR_PRE;
      ST_SR_PRE:    if (t_done) state_d = ST_READY;
      default:      state_d = ST_PAUSE;
    endcase
  end

  always_comb begin
    case (speed_grade)
      2'd0:    rp_len = TW'(RP0_CYC);
      2'd1:    rp_len = TW'(RP1_CYC);
      default: rp_len = TW'(RP2_CYC);
    endcase
  end

  always_comb begin
    case (state_d)
      ST_INIT_CAS, ST_SR_CAS: t_len = TW'(LEAD_CYC);
      ST_INIT_RAS:            t_len = TW'(INIT_RAS_CYC);
      ST_INIT_PRE:            t_len = TW'(INIT_PRE_CYC);
      ST_SR_HOLD:             t_len = TW'(DWELL_CYC);
      ST_SR_PRE:              t_len = rp_len;
      default:                t_len = TW'(1);
    endcase
  end

  assign t_load = (state_d != state_q);

  seq_timer #(
    .W       (TW),
    .RST_VAL (TW'(PAUSE_CYC))
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (t_load),
    .len   (t_len),
    .done  (t_done)
  );

  init_counter #(.W(CW)) u_init_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q == ST_PAUSE),
    .inc   (init_step),
    .count (init_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           exit_pend_q <= 1'b0;
    else if (state_q == ST_SR_HOLD && t_load) exit_pend_q <= 1'b0;
    else if (in_sr && sr_exit_req)        exit_pend_q <= 1'b1;
  end

  assign next_strobes = strobes_for(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_PAUSE;
      strobe_q <= '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      ready    <= 1'b0;
      busy     <= 1'b1;
    end else begin
      state_q  <= state_d;
      strobe_q <= next_strobes;
      ready    <= (state_d == ST_READY);
      busy     <= (state_d != ST_READY);
    end
  end

  // One flop per byte lane, both fed from the same decode
  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= 1'b1;
      else        lane_q <= next_strobes.cas_n;
    end
  end

  assign ras_n  = strobe_q.ras_n;
  assign we_n   = strobe_q.we_n;
  assign ucas_n = g_lane[1].lane_q;
  assign lcas_n = g_lane[0].lane_q;

  // ---------------- assertion support ----------------
  logic [TW-1:0] ras_low_run;
  logic [7:0]    ras_fall_tot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_low_run  <= '0;
      ras_fall_tot <= '0;
    end else begin
      if (ras_n)                  ras_low_run <= '0;
      else if (ras_low_run != '1) ras_low_run <= ras_low_run + TW'(1);
      if (ras_n && !next_strobes.ras_n && ras_fall_tot != 8'hFF)
        ras_fall_tot <= ras_fall_tot + 8'd1;
    end
  end

  // R3: exit only after the row strobe has been low for the whole dwell
  a_r3_dwell_min: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit_fire |-> (ras_low_run >= TW'(DWELL_CYC - 1)));

  // R2, R7: every row-strobe fall is preceded by column strobes already low
  a_r7_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!ucas_n && $past(!ucas_n)));

  // R5: a column release ahead of the row strobe lasts at most one cycle
  a_r5_cas_release_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ucas_n) && !ras_n) |=> ras_n);

  // R6: byte lanes never staggered
  a_r6_lanes_paired: assert property (@(posedge clk) disable iff (!rst_n)
    ucas_n == lcas_n);

  // R2: ready first rises only after the warm-up refreshes
  a_r2_init_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (ras_fall_tot >= INIT_N8));

  // R8: ready only with all strobes idle
  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ras_n && ucas_n && lcas_n && we_n && !busy));

endmodule

// File: tb/dram_selfrefresh_seq_bench.sv
`timescale 1ns/1ps
module dram_selfrefresh_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sr_enter_req, sr_exit_req;
  logic [1:0] speed_grade;
  logic       ras_n, ucas_n, lcas_n, we_n, ready, busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  dram_selfrefresh_seq u_dram_selfrefresh_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .sr_enter_req (sr_enter_req),
    .sr_exit_req  (sr_exit_req),
    .speed_grade  (speed_grade),
    .ras_n        (ras_n),
    .ucas_n       (ucas_n),
    .lcas_n       (lcas_n),
    .we_n         (we_n),
    .ready        (ready),
    .busy         (busy)
  );

  // Independent cycle arithmetic at 8 ns
  function automatic int cyc8(input int ns);
    int c;
    c = (ns * 1000) / 8000;
    if (c * 8000 < ns * 1000) c = c + 1;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int grade_ns(input int g);
    if (g == 0) return 90;
    if (g == 1) return 110;
    return 130;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sr_enter_req = 1'b0; sr_exit_req = 1'b0; speed_grade = 2'd0;
    repeat (3) tick();
    check(ras_n && ucas_n && lcas_n && we_n, "R1", "strobes high in reset",
          {ras_n, ucas_n, lcas_n, we_n}, 15);
    check(!ready && busy, "R1", "flags in reset", {ready, busy}, 1);
  endtask

  task automatic t_powerup();
    int pcount, falls, cbr_bad, mism, we_bad, n;
    bit prev_ras, prev_ucas;
    rst_n = 1'b1;
    tick();
    pcount = 0;
    while (ras_n && ucas_n && lcas_n && pcount < 30000) begin
      pcount++;
      sr_enter_req = (pcount == 100);   // R9: ignored while not ready
      sr_exit_req  = (pcount == 200);   // R9: ignored outside self-refresh
      tick();
    end
    sr_enter_req = 1'b0; sr_exit_req = 1'b0;
    check(pcount >= cyc8(200000), "R1", "power-up quiet cycles", pcount, cyc8(200000));
    check(!ucas_n && ras_n, "R2", "first refresh starts with CAS", {ucas_n, ras_n}, 1);
    falls = 0; cbr_bad = 0; mism = 0; we_bad = 0; n = 0;
    prev_ras = ras_n; prev_ucas = ucas_n;
    while (!ready && n < 5000) begin
      if (ucas_n != lcas_n) mism++;
      if (!we_n) we_bad++;
      prev_ras = ras_n; prev_ucas = ucas_n;
      n++;
      tick();
      if (prev_ras && !ras_n) begin
        falls++;
        if (prev_ucas) cbr_bad++;
      end
    end
    check(falls == 8, "R2", "warm-up refresh count", falls, 8);
    check(cbr_bad == 0, "R2", "refreshes not CAS-first", cbr_bad, 0);
    check(mism == 0, "R6", "lane mismatch during init", mism, 0);
    check(we_bad == 0, "R7", "we_n low during init", we_bad, 0);
    check(ready && !busy, "R8", "ready after init", {ready, busy}, 2);
    repeat (10) tick();
    check(ready && ras_n && ucas_n, "R9", "enter during pause was ignored",
          {ready, ras_n, ucas_n}, 7);
  endtask

  task automatic t_ignore_exit();
    int bad;
    bad = 0;
    sr_exit_req = 1'b1; tick(); sr_exit_req = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (!(ready && ras_n && ucas_n && lcas_n && !busy)) bad++;
      tick();
    end
    check(bad == 0, "R9", "exit while idle changed outputs", bad, 0);
  endtask

  task automatic t_sr(input int grade, input int exit_at);
    int lead, low, rel, mism, since_exit, pre, pre_bad, exp_pre;
    bit exit_sent;
    speed_grade = 2'(grade);
    sr_enter_req = 1'b1; tick(); sr_enter_req = 1'b0;
    check(!ucas_n && !lcas_n && ras_n, "R7", "entry CAS falls with RAS high",
          {ucas_n, lcas_n, ras_n}, 1);
    check(!ready && busy, "R8", "ready drops on entry", {ready, busy}, 1);
    lead = 0;
    while (ras_n && lead < 100) begin lead++; tick(); end
    check(lead >= 1 && !ucas_n, "R7", "RAS falls after CAS", lead, 2);
    low = 0; rel = 0; mism = 0; since_exit = 0; exit_sent = 1'b0;
    while (!ras_n && low < 20000) begin
      if (ucas_n != lcas_n) mism++;
      if (ucas_n) rel++;
      if (low == 51)
        check(!ucas_n && !ras_n && !ready, "R9", "enter during self-refresh ignored",
              {ucas_n, ras_n, ready}, 0);
      low++;
      sr_enter_req = (low == 50);
      sr_exit_req  = (low == exit_at);
      if (low == exit_at) exit_sent = 1'b1;
      tick();
      sr_enter_req = 1'b0; sr_exit_req = 1'b0;
      if (exit_sent) since_exit++;
    end
    check(ras_n == 1'b1, "R3", "exit request honoured", ras_n, 1);
    check(low >= cyc8(100000), "R3", "self-refresh RAS low cycles", low, cyc8(100000));
    if (exit_at > cyc8(100000))
      check(since_exit <= 3, "R3", "late exit latency", since_exit, 2);
    check(rel == 1, "R5", "CAS lead on exit", rel, 1);
    check(mism == 0, "R6", "lane mismatch in self-refresh", mism, 0);
    exp_pre = cyc8(grade_ns(grade));
    pre = 0; pre_bad = 0;
    while (!ready && pre < 200) begin
      if (!ras_n || ucas_n != 1'b1 || !busy) pre_bad++;
      pre++;
      tick();
    end
    check(pre >= exp_pre && pre <= exp_pre + 1, "R4", "precharge cycles", pre, exp_pre);
    check(pre_bad == 0, "R4", "strobes or busy wrong in precharge", pre_bad, 0);
    check(ready && !busy && we_n, "R8", "ready after precharge", {ready, busy, we_n}, 5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_powerup();
    t_ignore_exit();
    t_sr(0, 100);                  // early exit held pending
    t_sr(1, 100);
    t_sr(2, cyc8(100000) + 200);   // exit after dwell
    t_sr(3, 300);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule